// File: doc/BRIEF.md
# Interleaved SEC-DED Word Codec

This block protects a register-width data word with sixteen small single-error-correcting, double-error-detecting codes instead of one wide code. Each 4-bit lane of the word gets its own 8-bit extended Hamming codeword: four data bits plus four check bits. The lanes are interleaved across the word, so any run of neighbouring bits that are upset together lands in many different codewords, and each of those codewords sees at most one error.

An encoder turns a data word into a check word of equal width, to be stored next to it. A decoder takes a stored data word and its check word and returns the corrected data. It also returns two flags, each ORed over all lanes: one says at least one lane was corrected, the other says at least one lane held an uncorrectable double error. A half-width mode codes a value of half the width with a check field of half the width, for narrow operands. Both paths are purely combinational, and the width is a parameter, so 16-bit and 32-bit words are also covered.

Top module: `ihc_codec`

## Requirements
- R1: With `half_i`=0, lane i (0..15) takes the data bits d1=bit i, d2=bit i+16, d3=bit i+32 and d4=bit i+48. Its check bits are p1=d1^d2^d4, p2=d1^d3^d4, p3=d2^d3^d4, and p0 is the XOR of d1..d4 and p1..p3. Check bit pj of lane i is driven on `enc_check_o` bit j*16+i. For example, data 1 gives check 64'h0000_0001_0001_0001.
- R2: When every lane of the received data and check words is a valid codeword, `dec_data_o` equals `dec_data_i`, and `dec_sec_o` and `dec_ded_o` are both 0.
- R3: A single flipped data bit in a lane is restored on `dec_data_o`, with `dec_sec_o`=1 and `dec_ded_o`=0.
- R4: A single flipped check bit in a lane, including p0, leaves `dec_data_o` equal to the original data, with `dec_sec_o`=1 and `dec_ded_o`=0.
- R5: Two flipped bits within one lane set `dec_ded_o`=1. Unless another lane needs correction, `dec_sec_o` stays 0. The data bits of that lane pass through unchanged.
- R6: With `half_i`=0, a burst of 1 to 16 adjacent flipped bits confined to the data word, or confined to the check word, is fully corrected with `dec_ded_o`=0.
- R7: The flags are the OR over all lanes. A word with a single-error lane and a double-error lane raises both flags and still corrects the single-error lane.
- R8: With `half_i`=1, only eight lanes are used: lane i (0..7) takes bits i, i+8, i+16 and i+24, and check bit pj sits at position j*8+i. The upper half of `enc_data_i`, `dec_data_i` and `dec_check_i` is ignored, and the upper half of `enc_check_o` and `dec_data_o` is driven to 0.
- R9: With `half_i`=1, a burst of 1 to 8 adjacent flipped bits within the lower 32 bits of the data word, or of the check word, is fully corrected with `dec_ded_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| half_i | input | 1 | 1 selects half-width coding of the lower half |
| enc_data_i | input | 64 | Data word to encode |
| enc_check_o | output | 64 | Interleaved check word for `enc_data_i` |
| dec_data_i | input | 64 | Stored data word to check |
| dec_check_i | input | 64 | Stored check word |
| dec_data_o | output | 64 | Corrected data word |
| dec_sec_o | output | 1 | At least one lane had a single error that was fixed |
| dec_ded_o | output | 1 | At least one lane had an uncorrectable double error |

## Verification
The block holds no state, so any wrong internal mapping shows at the ports in the same evaluation as the stimulus. A swapped lane bit or a misplaced check position shows as a wrong bit in `enc_check_o` for plain data. A wrong syndrome-to-bit table shows as a miscorrected bit when a single error is injected in that lane. The bench therefore pairs random data with injected single, double, burst and mixed errors in both width modes. It compares every output against a brute-force decoder that searches for the nearest codeword.

// File: rtl/ihc_pkg.sv
package ihc_pkg;

    // Check nibble layout: [0]=overall parity, [1..3]=Hamming parities
    function automatic logic [3:0] nib_checks(input logic [3:0] d);
        logic p1, p2, p3, p0;
        p1 = d[0] ^ d[1] ^ d[3];
        p2 = d[0] ^ d[2] ^ d[3];
        p3 = d[1] ^ d[2] ^ d[3];
        p0 = (^d) ^ p1 ^ p2 ^ p3;
        return {p3, p2, p1, p0};
    endfunction

    typedef struct packed {
        logic [3:0] data;
        logic       sec;
        logic       ded;
    } nib_res_t;

endpackage

// File: rtl/ihc_nib_enc.sv
module ihc_nib_enc
    import ihc_pkg::*;
(
    input  logic [3:0] d_i,
    output logic [3:0] c_o
);
    always_comb begin
        c_o = nib_checks(d_i);
    end
endmodule

// File: rtl/ihc_nib_dec.sv
module ihc_nib_dec
    import ihc_pkg::*;
(
    input  logic [3:0] d_i,
    input  logic [3:0] c_i,
    output logic [3:0] d_o,
    output logic       sec_o,
    output logic       ded_o
);
    logic [2:0] syn;
    logic       par_err;
    nib_res_t   res_d;

    always_comb begin
        syn[0]  = c_i[1] ^ d_i[0] ^ d_i[1] ^ d_i[3];
        syn[1]  = c_i[2] ^ d_i[0] ^ d_i[2] ^ d_i[3];
        syn[2]  = c_i[3] ^ d_i[1] ^ d_i[2] ^ d_i[3];
        par_err = ^{d_i, c_i};

        res_d.data = d_i;
        res_d.sec  = 1'b0;
        res_d.ded  = 1'b0;
        if (par_err) begin
            // odd weight: one bit flipped, syndrome names its Hamming position
            res_d.sec = 1'b1;
            case (syn)
                3'd3:    res_d.data[0] = ~d_i[0];
                3'd5:    res_d.data[1] = ~d_i[1];
                3'd6:    res_d.data[2] = ~d_i[2];
                3'd7:    res_d.data[3] = ~d_i[3];
                default: res_d.data    = d_i;
            endcase
        end else if (syn != 3'd0) begin
            res_d.ded = 1'b1;
        end

        d_o   = res_d.data;
        sec_o = res_d.sec;
        ded_o = res_d.ded;
    end

    always_comb begin
        if (!$isunknown({d_i, c_i})) begin
            AST_SEC_DED_EXCL: assert (!(sec_o && ded_o)); // R5
            AST_CLEAN_PASS: assert (sec_o || (d_o == d_i)); // R2
            AST_ONE_FIX: assert ($countones(d_o ^ d_i) <= 1); // R3
            AST_CHK_ERR_NO_FIX: assert (!(sec_o && (syn inside {3'd0, 3'd1, 3'd2, 3'd4})) || (d_o == d_i)); // R4
        end
    end
endmodule

// File: rtl/ihc_lane_map.sv
module ihc_lane_map #(
    parameter int DATA_W = 64
) (
    input  logic                           half_i,
    input  logic [DATA_W-1:0]              word_i,
    output logic [DATA_W/4-1:0][3:0]       lanes_o
);
    localparam int LANES_F = DATA_W / 4;
    localparam int LANES_H = LANES_F / 2;

    always_comb begin
        lanes_o = '0;
        for (int g = 0; g < LANES_F; g++) begin
            for (int k = 0; k < 4; k++) begin
                if (!half_i)
                    lanes_o[g][k] = word_i[g + k*LANES_F];
                else if (g < LANES_H)
                    lanes_o[g][k] = word_i[g + k*LANES_H];
            end
        end
    end
endmodule

// File: rtl/ihc_lane_unmap.sv
module ihc_lane_unmap #(
    parameter int DATA_W = 64
) (
    input  logic                           half_i,
    input  logic [DATA_W/4-1:0][3:0]       lanes_i,
    output logic [DATA_W-1:0]              word_o
);
    localparam int LANES_F = DATA_W / 4;
    localparam int LANES_H = LANES_F / 2;

    always_comb begin
        word_o = '0;
        for (int g = 0; g < LANES_F; g++) begin
            for (int k = 0; k < 4; k++) begin
                if (!half_i)
                    word_o[g + k*LANES_F] = lanes_i[g][k];
                else if (g < LANES_H)
                    word_o[g + k*LANES_H] = lanes_i[g][k];
            end
        end
    end
endmodule

// File: rtl/ihc_codec.sv
module ihc_codec #(
    parameter int DATA_W = 64
) (
    input  logic              half_i,
    input  logic [DATA_W-1:0] enc_data_i,
    output logic [DATA_W-1:0] enc_check_o,
    input  logic [DATA_W-1:0] dec_data_i,
    input  logic [DATA_W-1:0] dec_check_i,
    output logic [DATA_W-1:0] dec_data_o,
    output logic              dec_sec_o,
    output logic              dec_ded_o
);
    localparam int LANES = DATA_W / 4;
    localparam int HALF  = DATA_W / 2;

    logic [LANES-1:0][3:0] enc_lanes, enc_chk_lanes;
    logic [LANES-1:0][3:0] dec_lanes, dec_chk_lanes, fix_lanes;
    logic [LANES-1:0]      lane_sec, lane_ded;

    ihc_lane_map #(.DATA_W(DATA_W)) u_enc_gather (
        .half_i(half_i), .word_i(enc_data_i), .lanes_o(enc_lanes));
    ihc_lane_map #(.DATA_W(DATA_W)) u_dec_gather (
        .half_i(half_i), .word_i(dec_data_i), .lanes_o(dec_lanes));
    ihc_lane_map #(.DATA_W(DATA_W)) u_chk_gather (
        .half_i(half_i), .word_i(dec_check_i), .lanes_o(dec_chk_lanes));

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        ihc_nib_enc u_enc (
            .d_i(enc_lanes[g]),
            .c_o(enc_chk_lanes[g]));
        ihc_nib_dec u_dec (
            .d_i  (dec_lanes[g]),
            .c_i  (dec_chk_lanes[g]),
            .d_o  (fix_lanes[g]),
            .sec_o(lane_sec[g]),
            .ded_o(lane_ded[g]));
    end

    ihc_lane_unmap #(.DATA_W(DATA_W)) u_enc_scatter (
        .half_i(half_i), .lanes_i(enc_chk_lanes), .word_o(enc_check_o));
    ihc_lane_unmap #(.DATA_W(DATA_W)) u_dec_scatter (
        .half_i(half_i), .lanes_i(fix_lanes), .word_o(dec_data_o));

    always_comb begin
        dec_sec_o = |lane_sec;
        dec_ded_o = |lane_ded;
    end

    always_comb begin
        if (!$isunknown({half_i, enc_data_i, dec_data_i, dec_check_i})) begin
            AST_HALF_UPPER_ZERO: assert (!half_i ||
                ((dec_data_o[DATA_W-1:HALF] == '0) && (enc_check_o[DATA_W-1:HALF] == '0))); // R8
            AST_ROUND_TRIP: assert (!((dec_data_i == enc_data_i) && (dec_check_i == enc_check_o))
                || (!dec_sec_o && !dec_ded_o && (dec_data_o == (half_i ?
                   {{HALF{1'b0}}, dec_data_i[HALF-1:0]} : dec_data_i)))); // R2
        end
    end
endmodule

// File: tb/test_ihc_codec.sv
module test_ihc_codec;
    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic        half_i;
    logic [63:0] enc_data_i, enc_check_o, dec_data_i, dec_check_i, dec_data_o;
    logic        dec_sec_o, dec_ded_o;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 0;

    ihc_codec i_ihc_codec (
        .half_i(half_i), .enc_data_i(enc_data_i), .enc_check_o(enc_check_o),
        .dec_data_i(dec_data_i), .dec_check_i(dec_check_i),
        .dec_data_o(dec_data_o), .dec_sec_o(dec_sec_o), .dec_ded_o(dec_ded_o));

    // model: Hamming positions 1..7, data at 3,5,6,7; p_b covers positions with bit b set
    function automatic logic [3:0] m_nib(input logic [3:0] d);
        logic [7:1] cw;
        logic [3:0] c;
        cw = '0;
        cw[3] = d[0]; cw[5] = d[1]; cw[6] = d[2]; cw[7] = d[3];
        c = '0;
        for (int b = 0; b < 3; b++)
            for (int p = 1; p < 8; p++)
                if (((p >> b) & 1) == 1 && p != (1 << b)) c[b+1] ^= cw[p];
        c[0] = ^{d, c[3:1]};
        return c;
    endfunction

    function automatic int lanes_of(input bit h);
        return h ? 8 : 16;
    endfunction

    function automatic logic [63:0] m_enc(input logic [63:0] d, input bit h);
        logic [63:0] c;
        int n;
        logic [3:0] nib, cn;
        n = lanes_of(h);
        c = '0;
        for (int g = 0; g < n; g++) begin
            for (int k = 0; k < 4; k++) nib[k] = d[g + k*n];
            cn = m_nib(nib);
            for (int j = 0; j < 4; j++) c[g + j*n] = cn[j];
        end
        return c;
    endfunction

    // brute force nearest-codeword decode
    function automatic void m_dec(input logic [63:0] d, input logic [63:0] c, input bit h,
                                  output logic [63:0] fix, output bit sec, output bit ded);
        int n;
        logic [7:0] cw, t;
        bit found;
        n = lanes_of(h);
        fix = '0; sec = 0; ded = 0;
        for (int g = 0; g < n; g++) begin
            for (int k = 0; k < 4; k++) begin
                cw[k] = d[g + k*n]; cw[4+k] = c[g + k*n];
            end
            if (m_nib(cw[3:0]) != cw[7:4]) begin
                found = 0;
                for (int b = 0; b < 8; b++) begin
                    t = cw ^ (8'd1 << b);
                    if (!found && m_nib(t[3:0]) == t[7:4]) begin
                        found = 1; cw = t;
                    end
                end
                if (found) sec = 1; else ded = 1;
            end
            for (int k = 0; k < 4; k++) fix[g + k*n] = cw[k];
        end
    endfunction

    task automatic chk(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic run_case(input string tag, input bit h, input logic [63:0] d,
                            input logic [63:0] derr, input logic [63:0] cerr);
        logic [63:0] clean_c, rd, rc, efix;
        bit esec, eded;
        @(negedge clk);
        clean_c = m_enc(d, h);
        rd = d ^ derr;
        rc = clean_c ^ cerr;
        if (h) begin   // garbage in the ignored upper half
            rc[63:32] = {$urandom};
            rd[63:32] = {$urandom};
        end
        half_i = h; enc_data_i = d; dec_data_i = rd; dec_check_i = rc;
        m_dec(rd, rc, h, efix, esec, eded);
        @(posedge clk); #1;
        chk(h ? "R8" : "R1", "enc_check", enc_check_o, clean_c);
        chk(tag, "dec_data", dec_data_o, efix);
        chk(tag, "sec", {63'd0, dec_sec_o}, {63'd0, esec});
        chk(tag, "ded", {63'd0, dec_ded_o}, {63'd0, eded});
    endtask

    function automatic logic [63:0] cw_bit(input int g, input int b, input int n, output bit in_chk);
        in_chk = (b >= 4);
        return 64'd1 << (g + (b % 4) * n);
    endfunction

    task automatic inject_bit(input int g, input int b, input int n,
                              inout logic [63:0] de, inout logic [63:0] ce);
        bit ic;
        logic [63:0] m;
        m = cw_bit(g, b, n, ic);
        if (ic) ce ^= m; else de ^= m;
    endtask

    initial begin
        #800000;
        n_errors++; n_checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        logic [63:0] d, de, ce, m;
        bit h;
        int sel, n, g, b1, b2, len, st;
        void'($urandom(32'd4711));
        half_i = 0; enc_data_i = '0; dec_data_i = '0; dec_check_i = '0;
        @(posedge clk); #1;
        chk("R2", "idle data", dec_data_o, 64'd0);
        chk("R1", "idle check", enc_check_o, 64'd0);
        chk("R2", "idle flags", {62'd0, dec_sec_o, dec_ded_o}, 64'd0);

        // directed
        @(negedge clk); enc_data_i = 64'd1; @(posedge clk); #1;
        chk("R1", "hand encode", enc_check_o, 64'h0000_0001_0001_0001);
        @(negedge clk); half_i = 1; enc_data_i = 64'hFFFF_FFFF_0000_0001; @(posedge clk); #1;
        chk("R8", "hand encode half", enc_check_o, 64'h0000_0000_0001_0101);
        run_case("R4", 0, 64'h0123_4567_89AB_CDEF, 0, 64'h1);             // p0 of lane 0
        run_case("R6", 0, 64'hDEAD_BEEF_0BAD_F00D, 64'h0000_FFFF_0000_0000, 0);
        run_case("R6", 0, 64'hDEAD_BEEF_0BAD_F00D, 0, 64'h00FF_FF00_0000_0000);
        run_case("R9", 1, 64'h0000_0000_CAFE_1234, 64'h0000_0000_00FF_0000, 0);
        run_case("R5", 0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0001_0000_0000_0001, 0);
        run_case("R7", 0, 64'h5555_AAAA_3333_CCCC, 64'h0000_0000_0002_0004, 64'h0004);

        for (int it = 0; it < 400; it++) begin
            d = {$urandom, $urandom};
            h = ($urandom % 4) == 0;
            n = h ? 8 : 16;
            if (h) d[63:32] = '0;
            de = '0; ce = '0;
            sel = $urandom % 6;
            g = $urandom % n;
            b1 = $urandom % 8;
            b2 = (b1 + 1 + ($urandom % 7)) % 8;
            case (sel)
                0: run_case(h ? "R8" : "R2", h, d, de, ce);
                1: begin
                    inject_bit(g, $urandom % 4, n, de, ce);
                    run_case(h ? "R8" : "R3", h, d, de, ce);
                end
                2: begin
                    inject_bit(g, 4 + ($urandom % 4), n, de, ce);
                    run_case(h ? "R8" : "R4", h, d, de, ce);
                end
                3: begin
                    inject_bit(g, b1, n, de, ce);
                    inject_bit(g, b2, n, de, ce);
                    run_case(h ? "R8" : "R5", h, d, de, ce);
                end
                4: begin
                    len = 1 + ($urandom % n);
                    st = $urandom % (4*n - len + 1);
                    m = ((64'd1 << len) - 64'd1) << st;
                    if ($urandom % 2) de = m; else ce = m;
                    run_case(h ? "R9" : "R6", h, d, de, ce);
                end
                default: begin
                    inject_bit(g, b1, n, de, ce);
                    inject_bit(g, b2, n, de, ce);
                    inject_bit((g + 1) % n, $urandom % 8, n, de, ce);
                    run_case(h ? "R8" : "R7", h, d, de, ce);
                end
            endcase
        end
        done = 1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule